// File: doc/BRIEF.md
# Bit-Serial Distributed-Arithmetic Multiply-Accumulate Unit

This unit forms one inner product of eight signed samples with eight fixed coefficients, without using a multiplier. A start pulse loads all eight samples at once. The unit then walks through the sample bits one position per cycle, starting at the least significant bit. In each cycle it gathers the current bit of every sample into an 8-bit address.

That address selects a precomputed sum of coefficients from a constant table. The table is built at elaboration from the coefficient parameter. The selected sum is added into a 16-bit running accumulator, and the accumulator is halved (arithmetic shift right) on every step. The last step handles the sign bit, so it subtracts the table value instead of adding it.

The table register is loaded only when the address differs from the one it last captured, so runs of identical bit-slices cause no table activity. The accumulator adder is a carry-select adder. Its stage widths grow by one bit per stage, and each stage resolves its carry with a ripple-style switched carry chain. A one-cycle done pulse marks the result, which stays on the output until the next start.

Top module: `da_shift_acc`

## Requirements
- R1: After reset, `result_o` is 0, and `done_o` and `busy_o` are low.
- R2: In the cycle after a start edge, `busy_o` is high and `result_o` reads 0. Sample k is taken from `samples_i[k*9 +: 9]` as a 9-bit two's complement value.
- R3: `done_o` goes high exactly 10 clock edges after the start edge and stays high for one cycle only. `busy_o` is low while `done_o` is high.
- R4: When `done_o` is high, `result_o` equals floor(sum over k of c_k*x_k / 256) as a 16-bit two's complement number. Here c_k is the 12-bit signed coefficient at `COEFS[k*12 +: 12]`, and x_k is in -255..255.
- R5: Slices are taken least significant bit first. In each slice, bit k of the address comes from sample k. The ninth slice (the sign bit) subtracts its table value, and all earlier slices add theirs.
- R6: Table entry a holds the sum of the c_k whose address bit k is set, so entry 0 holds zero.
- R7: The table register loads only while busy and only when the slice address differs from the last address loaded. Otherwise it keeps its value, and results stay correct when slices repeat within or across blocks.
- R8: The accumulator adder returns the 17-bit sum of its two 16-bit operands and carry-in. Its carry-select stages start at 2 bits and widen by one per stage.
- R9: A start while busy abandons the block in progress. No done pulse is produced for the abandoned block, and the new block completes 10 edges after the new start.
- R10: After the done pulse, `result_o` holds its value until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Loads samples and begins a block |
| samples_i | input | 72 | Eight 9-bit signed samples, sample k at bits k*9 upward |
| busy_o | output | 1 | High while bit-slices are being fetched |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| result_o | output | 16 | Accumulated inner product, scaled by 1/256 |

## Verification
A stale table register, a wrong carry mux in one adder stage, or a sign slice that adds instead of subtracting each corrupts the value in `result_o` at the next done pulse, ten cycles after start. The sweeps therefore compare every block against the inner product worked out directly from the integer samples. A single sample is swept over its whole range, and repeated-slice patterns target the skipped table reads. An off-by-one in the slice counter moves the done pulse and is caught in that same block. A restart that leaks state shows up as a spurious pulse or a wrong sum.

// File: rtl/da_pkg.sv
package da_pkg;

  localparam int DA_TAPS = 8;
  localparam int DA_ADDR_W = DA_TAPS;

  // low bit index of carry-select stage idx when widths are first, first+1, ...
  function automatic int csel_stage_lo(input int first, input int idx);
    return idx * first + (idx * (idx - 1)) / 2;
  endfunction

  function automatic int csel_stage_count(input int width, input int first);
    int n;
    n = 0;
    for (int i = 0; i < width; i++) begin
      if (csel_stage_lo(first, i) < width) n = i + 1;
    end
    return n;
  endfunction

  function automatic int csel_stage_width(input int width, input int first, input int idx);
    int lo;
    int w;
    lo = csel_stage_lo(first, idx);
    w = first + idx;
    if (lo + w > width) w = width - lo;
    return w;
  endfunction

endpackage

// File: rtl/da_manchester_stage.sv
module da_manchester_stage #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] s_o,
  output logic         c_o
);

  logic [W-1:0] gen;
  logic [W-1:0] prop;

  assign gen  = a_i & b_i;
  assign prop = a_i ^ b_i;

  // switched carry chain: each node either passes the incoming carry,
  // is forced high by generate, or is pulled low (kill)
  always_comb begin
    logic carry;
    carry = c_i;
    s_o = '0;
    for (int i = 0; i < W; i++) begin
      s_o[i] = prop[i] ^ carry;
      carry = gen[i] | (prop[i] & carry);
    end
    c_o = carry;
  end

endmodule

// File: rtl/da_csel_adder.sv
module da_csel_adder
  import da_pkg::*;
#(
  parameter int W     = 16,
  parameter int FIRST = 2
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ci_i,
  output logic [W-1:0] s_o,
  output logic         co_o
);

  localparam int NST = csel_stage_count(W, FIRST);

  logic sc [NST+1];

  assign sc[0] = ci_i;
  assign co_o  = sc[NST];

  for (genvar i = 0; i < NST; i++) begin : g_stage
    localparam int LO = csel_stage_lo(FIRST, i);
    localparam int SW = csel_stage_width(W, FIRST, i);

    if (i == 0) begin : g_head
      logic cout_w;
      da_manchester_stage #(.W(SW)) u_chain (
        .a_i(a_i[LO +: SW]),
        .b_i(b_i[LO +: SW]),
        .c_i(sc[0]),
        .s_o(s_o[LO +: SW]),
        .c_o(cout_w)
      );
      assign sc[1] = cout_w;
    end else begin : g_sel
      logic [SW-1:0] sum0;
      logic [SW-1:0] sum1;
      logic          cy0;
      logic          cy1;
      da_manchester_stage #(.W(SW)) u_chain0 (
        .a_i(a_i[LO +: SW]),
        .b_i(b_i[LO +: SW]),
        .c_i(1'b0),
        .s_o(sum0),
        .c_o(cy0)
      );
      da_manchester_stage #(.W(SW)) u_chain1 (
        .a_i(a_i[LO +: SW]),
        .b_i(b_i[LO +: SW]),
        .c_i(1'b1),
        .s_o(sum1),
        .c_o(cy1)
      );
      assign s_o[LO +: SW] = sc[i] ? sum1 : sum0;
      assign sc[i+1]       = sc[i] ? cy1 : cy0;
    end
  end

endmodule

// File: rtl/da_coef_rom.sv
module da_coef_rom
  import da_pkg::*;
#(
  parameter int COEF_W = 12,
  parameter int ACC_W  = 16,
  parameter logic [DA_TAPS*COEF_W-1:0] COEFS = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_i,
  input  logic [DA_ADDR_W-1:0] addr_i,
  output logic                 rd_o,
  output logic [ACC_W-1:0]     data_o
);

  localparam int DEPTH = 1 << DA_ADDR_W;

  function automatic logic [ACC_W-1:0] tap_sum(input logic [DA_ADDR_W-1:0] a);
    logic [ACC_W-1:0]  s;
    logic [COEF_W-1:0] c;
    s = '0;
    for (int k = 0; k < DA_TAPS; k++) begin
      c = COEFS[k*COEF_W +: COEF_W];
      if (a[k]) s = s + {{(ACC_W-COEF_W){c[COEF_W-1]}}, c};
    end
    return s;
  endfunction

  logic [ACC_W-1:0]     table_w [DEPTH];
  logic [DA_ADDR_W-1:0] addr_q;

  for (genvar a = 0; a < DEPTH; a++) begin : g_entry
    assign table_w[a] = tap_sum(DA_ADDR_W'(a));
  end

  assign rd_o = en_i && (addr_i != addr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_o <= '0;
    end else if (rd_o) begin
      addr_q <= addr_i;
      data_o <= table_w[addr_i];
    end
  end

endmodule

// File: rtl/da_shift_acc.sv
module da_shift_acc
  import da_pkg::*;
#(
  parameter int SAMPLE_W   = 9,
  parameter int COEF_W     = 12,
  parameter int ACC_W      = 16,
  parameter int CSEL_FIRST = 2,
  parameter logic [DA_TAPS*COEF_W-1:0] COEFS = {
    -12'sd2009, -12'sd1703, -12'sd1138, -12'sd400,
     12'sd400,   12'sd1138,  12'sd1703,  12'sd2009}
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic [DA_TAPS*SAMPLE_W-1:0] samples_i,
  output logic                        busy_o,
  output logic                        done_o,
  output logic [ACC_W-1:0]            result_o
);

  localparam int CNT_W = $clog2(SAMPLE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLE_W - 1);

  logic [SAMPLE_W-1:0]  sreg [DA_TAPS];
  logic [CNT_W-1:0]     slice_cnt;
  logic                 fetch_v;
  logic                 fetch_last;
  logic [DA_ADDR_W-1:0] slice_addr;
  logic                 tbl_rd;
  logic [ACC_W-1:0]     tbl_q;
  logic [ACC_W-1:0]     add_a;
  logic [ACC_W-1:0]     add_b;
  logic                 add_ci;
  logic [ACC_W-1:0]     add_s;
  logic                 add_co;

  always_comb begin
    for (int k = 0; k < DA_TAPS; k++) slice_addr[k] = sreg[k][0];
  end

  da_coef_rom #(
    .COEF_W(COEF_W),
    .ACC_W (ACC_W),
    .COEFS (COEFS)
  ) u_rom (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (busy_o),
    .addr_i(slice_addr),
    .rd_o  (tbl_rd),
    .data_o(tbl_q)
  );

  // halve the running sum; the sign slice subtracts via inverted operand + 1
  assign add_a  = {result_o[ACC_W-1], result_o[ACC_W-1:1]};
  assign add_b  = fetch_last ? ~tbl_q : tbl_q;
  assign add_ci = fetch_last;

  da_csel_adder #(
    .W    (ACC_W),
    .FIRST(CSEL_FIRST)
  ) u_add (
    .a_i (add_a),
    .b_i (add_b),
    .ci_i(add_ci),
    .s_o (add_s),
    .co_o(add_co)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DA_TAPS; k++) sreg[k] <= '0;
      slice_cnt  <= '0;
      busy_o     <= 1'b0;
      fetch_v    <= 1'b0;
      fetch_last <= 1'b0;
      done_o     <= 1'b0;
      result_o   <= '0;
    end else if (start_i) begin
      for (int k = 0; k < DA_TAPS; k++) sreg[k] <= samples_i[k*SAMPLE_W +: SAMPLE_W];
      slice_cnt  <= '0;
      busy_o     <= 1'b1;
      fetch_v    <= 1'b0;
      fetch_last <= 1'b0;
      done_o     <= 1'b0;
      result_o   <= '0;
    end else begin
      done_o     <= fetch_v & fetch_last;
      fetch_v    <= busy_o;
      fetch_last <= busy_o && (slice_cnt == LAST);
      if (fetch_v) result_o <= add_s;
      if (busy_o) begin
        for (int k = 0; k < DA_TAPS; k++) sreg[k] <= sreg[k] >> 1;
        slice_cnt <= slice_cnt + 1'b1;
        if (slice_cnt == LAST) busy_o <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/da_shift_acc_chk.sv
module da_shift_acc_chk #(
  parameter int ACC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [ACC_W-1:0] result_o,
  input logic             tbl_rd,
  input logic [ACC_W-1:0] tbl_q,
  input logic [ACC_W-1:0] add_a,
  input logic [ACC_W-1:0] add_b,
  input logic             add_ci,
  input logic [ACC_W-1:0] add_s,
  input logic             add_co
);

  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (result_o == '0) && busy_o);

  a_r3_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r3_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  a_r7_read_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_rd |-> busy_o);

  a_r7_hold_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    !tbl_rd |=> $stable(tbl_q));

  a_r8_adder_sum: assert property (@(posedge clk) disable iff (!rst_n)
    {add_co, add_s} == ({1'b0, add_a} + {1'b0, add_b} + {{ACC_W{1'b0}}, add_ci}));

  a_r10_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !done_o && !start_i && !$past(busy_o)) |=> $stable(result_o));

endmodule

bind da_shift_acc da_shift_acc_chk #(.ACC_W(ACC_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .result_o(result_o),
  .tbl_rd  (tbl_rd),
  .tbl_q   (tbl_q),
  .add_a   (add_a),
  .add_b   (add_b),
  .add_ci  (add_ci),
  .add_s   (add_s),
  .add_co  (add_co)
);

// File: tb/da_shift_acc_test.sv
module da_shift_acc_test;

  localparam logic [95:0] COEFS = {
    -12'sd2009, -12'sd1703, -12'sd1138, -12'sd400,
     12'sd400,   12'sd1138,  12'sd1703,  12'sd2009};
  int cf [8] = '{2009, 1703, 1138, 400, -400, -1138, -1703, -2009};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [71:0] samples_i = '0;
  logic        busy_o;
  logic        done_o;
  logic [15:0] result_o;

  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  da_shift_acc #(.COEFS(COEFS)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .samples_i(samples_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [71:0] pack(input int x0, input int x1, input int x2, input int x3,
                                       input int x4, input int x5, input int x6, input int x7);
    logic [71:0] p;
    p[0*9 +: 9] = 9'(x0); p[1*9 +: 9] = 9'(x1);
    p[2*9 +: 9] = 9'(x2); p[3*9 +: 9] = 9'(x3);
    p[4*9 +: 9] = 9'(x4); p[5*9 +: 9] = 9'(x5);
    p[6*9 +: 9] = 9'(x6); p[7*9 +: 9] = 9'(x7);
    return p;
  endfunction

  // inner product from the integer values, floored after dividing by 256
  function automatic int expect_of(input logic [71:0] p);
    int y;
    y = 0;
    for (int k = 0; k < 8; k++) y += cf[k] * int'($signed(p[k*9 +: 9]));
    return y >>> 8;
  endfunction

  task automatic run_block(input logic [71:0] p, input string req);
    int e;
    e = expect_of(p);
    samples_i = p;
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o === 1'b1 && result_o === 16'd0, "R2", int'(result_o), 0);
    for (int i = 1; i < 10; i++) begin
      @(posedge clk);
      @(negedge clk);
      check(done_o === 1'b0, "R3 early done", int'(done_o), 0);
    end
    @(posedge clk);
    @(negedge clk);
    check(done_o === 1'b1 && busy_o === 1'b0, "R3 done at edge 10", int'(done_o), 1);
    check(int'($signed(result_o)) == e, req, int'($signed(result_o)), e);
    @(posedge clk);
    @(negedge clk);
    check(done_o === 1'b0, "R3 pulse width", int'(done_o), 0);
    check(int'($signed(result_o)) == e, "R10 hold", int'($signed(result_o)), e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    logic [71:0] pa;
    logic [71:0] pb;
    int eb;
    repeat (3) @(negedge clk);
    check(result_o === 16'd0 && done_o === 1'b0 && busy_o === 1'b0, "R1", int'(result_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_block(pack(0, 0, 0, 0, 0, 0, 0, 0), "R4 R6 zeros");
    run_block(pack(255, 255, 255, 255, 255, 255, 255, 255), "R4 all max");
    run_block(pack(-255, -255, -255, -255, -255, -255, -255, -255), "R5 all min");
    run_block(pack(-1, 0, 0, 0, 0, 0, 0, 0), "R5 R7 single tap sign run");
    run_block(pack(-1, -1, -1, -1, -1, -1, -1, -1), "R7 repeated slice");
    run_block(pack(-1, -1, -1, -1, -1, -1, -1, -1), "R7 repeat across blocks");
    run_block(pack(255, -255, 255, -255, 255, -255, 255, -255), "R4 R8 alternating");
    run_block(pack(-256, 0, 0, 0, 0, 0, 0, -256), "R5 sign only");
    for (int k = 0; k < 8; k++) begin
      logic [71:0] p;
      p = '0;
      p[k*9 +: 9] = 9'(1);
      run_block(p, "R6 one tap");
    end

    for (int v = -255; v <= 255; v++) begin
      run_block(pack((v * 37 + 11) % 256, -((v * 13) % 200), 100 - v / 3, v,
                     (v * 7) % 255, -v, 17, (v * v) % 255), "R4 R8 sweep");
    end

    for (int i = 0; i < 150; i++) begin
      logic [71:0] p;
      for (int k = 0; k < 8; k++) p[k*9 +: 9] = 9'(int'($urandom_range(510)) - 255);
      run_block(p, "R4 R5 random");
    end

    // R9: restart mid-block
    pa = pack(100, 50, -20, 7, 0, -90, 33, 1);
    pb = pack(-3, 200, 5, -77, 140, 0, -255, 64);
    eb = expect_of(pb);
    samples_i = pa;
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk);
      @(negedge clk);
      check(done_o === 1'b0, "R9 no early done", int'(done_o), 0);
    end
    samples_i = pb;
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    check(result_o === 16'd0, "R9 restart clears", int'(result_o), 0);
    for (int i = 1; i < 10; i++) begin
      @(posedge clk);
      @(negedge clk);
      check(done_o === 1'b0, "R9 abandoned block silent", int'(done_o), 0);
    end
    @(posedge clk);
    @(negedge clk);
    check(done_o === 1'b1, "R9 done after restart", int'(done_o), 1);
    check(int'($signed(result_o)) == eb, "R9 result", int'($signed(result_o)), eb);

    repeat (5) @(negedge clk);
    check(int'($signed(result_o)) == eb, "R10 idle hold", int'($signed(result_o)), eb);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule